// File: doc/BRIEF.md
# Timebase Capture-to-Trigger Unit

This block snapshots a free-running PWM timebase count when a chosen hardware event asserts, or whenever software issues a capture strobe. A 3-bit source code picks one of four event inputs: synchronisation, feed-forward, current limit, or a second fault line. Code 0 leaves the unit in software-only mode. The snapshot is presented on `cap_value` and announced by a one-cycle `cap_valid`.

When transfer is enabled, the cycle after each capture the unit writes half of the captured count into one of four trigger compare registers. These are indexed 0 to 3 and named C, D, E and F. The write comes with a one-cycle per-register write strobe. A downstream comparator can then place a trigger at the midpoint of the captured interval.

A four-state controller sequences the work:
- `ST_IDLE`: nothing to report.
- `ST_CAPT`: capture reported, no transfer pending.
- `ST_CAPT_ARM`: capture reported, transfer pending.
- `ST_WRITE`: transfer strobe visible, no new capture.

Transitions:
- Any state moves to `ST_CAPT_ARM` on a capture request while both enables are set.
- Any state moves to `ST_CAPT` on a capture request otherwise.
- `ST_CAPT_ARM` moves to `ST_WRITE` when no request arrives.
- Every other state with no request returns to `ST_IDLE`.

Top module: `ctt_capture_trigger`

## Requirements
- R1: While and after reset, `cap_value`, `cap_valid`, `trig_wr` and all four trigger values are zero until the first capture.
- R2: Source code 1, 2, 3 and 4 select `evt_in` bit 0 (sync), bit 1 (feed-forward), bit 2 (current limit) and bit 3 (fault 2). A rising edge on the selected bit requests a capture. The other bits have no effect.
- R3: Source code 0 (software only) and reserved codes 5, 6 and 7 never cause a hardware capture.
- R4: A high `sw_cap` in a cycle requests a capture whatever `src_sel` and `cap_en` hold.
- R5: With `cap_en` low, no hardware event causes a capture.
- R6: An event held high for several cycles causes exactly one capture, on its first high cycle.
- R7: A request sampled at clock edge k loads `cap_value` with the `tb_count` present at edge k. `cap_valid` is high for exactly the cycle after edge k.
- R8: If `cap_en` and `trig_en` are both high at a capture, the next edge loads `cap_value >> 1` into the trigger register chosen by `trig_sel`. The encoding is 0=C, 1=D, 2=E, 3=F, and register i occupies `trig_val` bits [i*CNT_W +: CNT_W]. The same edge raises `trig_wr[i]` alone for one cycle.
- R9: With `trig_en` or `cap_en` low at a capture, no trigger register is written. All trigger values stay unchanged whenever `trig_wr` is zero.
- R10: The destination register is taken from `trig_sel` at the capture edge. A later change of `trig_sel` does not redirect the pending write.
- R11: On captures in consecutive cycles, each pending write uses its own earlier captured value, not the newer one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_count | input | CNT_W | Free-running timebase count |
| evt_in | input | 4 | Event levels: sync, feed-forward, current limit, fault 2 |
| sw_cap | input | 1 | Software capture strobe |
| cap_en | input | 1 | Capture point enable |
| src_sel | input | 3 | Hardware capture source code |
| trig_en | input | 1 | Capture-to-trigger transfer enable |
| trig_sel | input | 2 | Destination trigger register |
| cap_value | output | CNT_W | Last captured count |
| cap_valid | output | 1 | One-cycle capture pulse |
| trig_val | output | 4*CNT_W | Trigger registers C..F, packed |
| trig_wr | output | 4 | One-cycle write strobe per trigger register |

## Verification
The bench drives events that stay high for many cycles, so a design that captured on level instead of edge would report a capture every cycle. It sweeps every source code, including the reserved ones, while toggling all event lines. A decoder off by one index, or one that let reserved codes through, would capture on the wrong line. It changes `trig_sel` in the cycle right after a capture, and it issues captures on consecutive cycles. A design that read the selector late, or wrote the newer snapshot, would hit the wrong register or store the wrong half value. Software strobes with `cap_en` low expose a design that gated software capture by the hardware enable.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

    localparam int SRC_W   = 3;
    localparam int EVT_NUM = 4;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CAPT     = 2'd1,
        ST_CAPT_ARM = 2'd2,
        ST_WRITE    = 2'd3
    } ctt_state_e;

    localparam logic [SRC_W-1:0] SRC_SW_ONLY = 3'd0;
    localparam logic [SRC_W-1:0] SRC_SYNC    = 3'd1;
    localparam logic [SRC_W-1:0] SRC_FFWD    = 3'd2;
    localparam logic [SRC_W-1:0] SRC_ILIM    = 3'd3;
    localparam logic [SRC_W-1:0] SRC_FLT2    = 3'd4;

endpackage

// File: rtl/ctt_edge_detect.sv
module ctt_edge_detect #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign rise[g] = lvl[g] & ~lvl_q[g];
    end

endmodule

// File: rtl/ctt_src_select.sv
module ctt_src_select #(
    parameter int N  = 4,
    parameter int SW = 3
) (
    input  logic [N-1:0]  rise,
    input  logic [SW-1:0] src_sel,
    input  logic          cap_en,
    output logic          hw_req
);

    // Code i+1 selects event bit i; code 0 and codes above N match nothing.
    always_comb begin
        hw_req = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (cap_en && (src_sel == SW'(i + 1))) begin
                hw_req = rise[i];
            end
        end
    end

endmodule

// File: rtl/ctt_trig_bank.sv
module ctt_trig_bank #(
    parameter int CNT_W = 16,
    parameter int NT    = 4,
    parameter int SEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [CNT_W-1:0]    wr_data,
    output logic [NT*CNT_W-1:0] trig_val,
    output logic [NT-1:0]       trig_wr
);

    for (genvar g = 0; g < NT; g++) begin : g_reg
        logic [CNT_W-1:0] val_q;
        logic             hit;

        assign hit = wr_en && (wr_sel == SEL_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q      <= '0;
                trig_wr[g] <= 1'b0;
            end else begin
                trig_wr[g] <= hit;
                if (hit) begin
                    val_q <= wr_data;
                end
            end
        end

        assign trig_val[g*CNT_W +: CNT_W] = val_q;
    end

endmodule

// File: rtl/ctt_capture_trigger.sv
module ctt_capture_trigger
    import ctt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NUM_TRIG = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W-1:0]          tb_count,
    input  logic [EVT_NUM-1:0]        evt_in,
    input  logic                      sw_cap,
    input  logic                      cap_en,
    input  logic [SRC_W-1:0]          src_sel,
    input  logic                      trig_en,
    input  logic [$clog2(NUM_TRIG)-1:0] trig_sel,
    output logic [CNT_W-1:0]          cap_value,
    output logic                      cap_valid,
    output logic [NUM_TRIG*CNT_W-1:0] trig_val,
    output logic [NUM_TRIG-1:0]       trig_wr
);

    localparam int TSEL_W = $clog2(NUM_TRIG);

    ctt_state_e         state, state_nx;
    logic [EVT_NUM-1:0] evt_rise;
    logic               hw_req;
    logic               cap_req;
    logic               arm_req;
    logic [TSEL_W-1:0]  sel_q;
    logic               xfer_go;
    logic [CNT_W-1:0]   half_val;

    ctt_edge_detect #(.N(EVT_NUM)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (evt_in),
        .rise  (evt_rise)
    );

    ctt_src_select #(.N(EVT_NUM), .SW(SRC_W)) u_src (
        .rise    (evt_rise),
        .src_sel (src_sel),
        .cap_en  (cap_en),
        .hw_req  (hw_req)
    );

    assign cap_req = sw_cap | hw_req;
    assign arm_req = cap_en & trig_en;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE: begin
                if (cap_req) state_nx = arm_req ? ST_CAPT_ARM : ST_CAPT;
                else         state_nx = ST_IDLE;
            end
            ST_CAPT: begin
                if (cap_req) state_nx = arm_req ? ST_CAPT_ARM : ST_CAPT;
                else         state_nx = ST_IDLE;
            end
            ST_CAPT_ARM: begin
                if (cap_req) state_nx = arm_req ? ST_CAPT_ARM : ST_CAPT;
                else         state_nx = ST_WRITE;
            end
            ST_WRITE: begin
                if (cap_req) state_nx = arm_req ? ST_CAPT_ARM : ST_CAPT;
                else         state_nx = ST_IDLE;
            end
        endcase
    end

    // Output and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_value <= '0;
            sel_q     <= '0;
        end else if (cap_req) begin
            cap_value <= tb_count;
            sel_q     <= trig_sel;
        end
    end

    assign cap_valid = (state == ST_CAPT) || (state == ST_CAPT_ARM);
    assign xfer_go   = (state == ST_CAPT_ARM);
    assign half_val  = cap_value >> 1;

    ctt_trig_bank #(.CNT_W(CNT_W), .NT(NUM_TRIG), .SEL_W(TSEL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (xfer_go),
        .wr_sel   (sel_q),
        .wr_data  (half_val),
        .trig_val (trig_val),
        .trig_wr  (trig_wr)
    );

endmodule

// File: rtl/ctt_capture_trigger_chk.sv
module ctt_capture_trigger_chk
    import ctt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NUM_TRIG = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [CNT_W-1:0]            tb_count,
    input logic                        sw_cap,
    input logic                        cap_en,
    input logic [SRC_W-1:0]            src_sel,
    input logic [CNT_W-1:0]            cap_value,
    input logic                        cap_valid,
    input logic [NUM_TRIG*CNT_W-1:0]   trig_val,
    input logic [NUM_TRIG-1:0]         trig_wr
);

    // R4
    sw_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_cap |=> cap_valid);

    // R7
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_cap |=> (cap_value == $past(tb_count)));

    // R3
    reserved_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_cap && (src_sel == 3'd0 || src_sel > 3'd4)) |=> !cap_valid);

    // R5
    cap_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_cap && !cap_en) |=> !cap_valid);

    // R8
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trig_wr));

    // R8
    strobe_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr != '0) |-> $past(cap_valid));

    // R9
    trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr == '0) |-> $stable(trig_val));

endmodule

bind ctt_capture_trigger ctt_capture_trigger_chk #(
    .CNT_W    (CNT_W),
    .NUM_TRIG (NUM_TRIG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tb_count  (tb_count),
    .sw_cap    (sw_cap),
    .cap_en    (cap_en),
    .src_sel   (src_sel),
    .cap_value (cap_value),
    .cap_valid (cap_valid),
    .trig_val  (trig_val),
    .trig_wr   (trig_wr)
);

// File: tb/ctt_capture_trigger_test.sv
`timescale 1ns/1ps
module ctt_capture_trigger_test;

    localparam int CW = 16;
    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] tb_count = '0;
    logic [3:0]    evt_in = '0;
    logic          sw_cap = 1'b0;
    logic          cap_en = 1'b0;
    logic [2:0]    src_sel = '0;
    logic          trig_en = 1'b0;
    logic [1:0]    trig_sel = '0;
    logic [CW-1:0] cap_value;
    logic          cap_valid;
    logic [NT*CW-1:0] trig_val;
    logic [NT-1:0] trig_wr;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R1";
    logic [CW-1:0] tbc = '0;

    // bench model state
    logic [3:0]    m_evt_q = '0;
    logic [CW-1:0] m_cap = '0;
    logic          m_valid = 1'b0;
    logic          m_arm = 1'b0;
    logic [1:0]    m_sel = '0;
    logic [CW-1:0] m_trig [NT];
    logic [NT-1:0] m_wr = '0;

    always #5 clk = ~clk;

    ctt_capture_trigger #(.CNT_W(CW), .NUM_TRIG(NT)) uut (
        .clk (clk), .rst_n (rst_n), .tb_count (tb_count), .evt_in (evt_in),
        .sw_cap (sw_cap), .cap_en (cap_en), .src_sel (src_sel),
        .trig_en (trig_en), .trig_sel (trig_sel), .cap_value (cap_value),
        .cap_valid (cap_valid), .trig_val (trig_val), .trig_wr (trig_wr)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("cap_value", 64'(cap_value), 64'(m_cap));
        chk("cap_valid", 64'(cap_valid), 64'(m_valid));
        chk("trig_wr", 64'(trig_wr), 64'(m_wr));
        for (int i = 0; i < NT; i++)
            chk($sformatf("trig_val[%0d]", i), 64'(trig_val[i*CW +: CW]), 64'(m_trig[i]));
    endtask

    function automatic logic hw_hit(input logic [3:0] rise, input logic ce, input logic [2:0] src);
        if (!ce) return 1'b0;
        case (src)
            3'd1: return rise[0];
            3'd2: return rise[1];
            3'd3: return rise[2];
            3'd4: return rise[3];
            default: return 1'b0;
        endcase
    endfunction

    task automatic cyc(input logic [3:0] e, input logic s, input logic ce, input logic [2:0] src,
                       input logic te, input logic [1:0] ts, input logic [CW-1:0] tb);
        logic req;
        @(negedge clk);
        compare_all();
        evt_in = e; sw_cap = s; cap_en = ce; src_sel = src;
        trig_en = te; trig_sel = ts; tb_count = tb;
        req = s | hw_hit(e & ~m_evt_q, ce, src);
        m_wr = '0;
        if (m_arm) begin
            m_trig[m_sel] = m_cap >> 1;
            m_wr[m_sel] = 1'b1;
        end
        if (req) begin
            m_cap = tb; m_valid = 1'b1; m_arm = ce & te; m_sel = ts;
        end else begin
            m_valid = 1'b0; m_arm = 1'b0;
        end
        m_evt_q = e;
    endtask

    task automatic go(input logic [3:0] e, input logic s, input logic ce, input logic [2:0] src,
                      input logic te, input logic [1:0] ts);
        tbc = tbc + 16'd37;
        cyc(e, s, ce, src, te, ts, tbc);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) go(4'h0, 1'b0, 1'b1, 3'd1, 1'b1, 2'd0);
    endtask

    initial begin
        for (int i = 0; i < NT; i++) m_trig[i] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        cur_tag = "R1";
        compare_all();
        @(negedge clk);
        rst_n = 1'b1;
        compare_all();

        cur_tag = "R2";
        for (int s = 1; s <= 4; s++) begin
            for (int b = 0; b < 4; b++) begin
                go(4'(1 << b), 1'b0, 1'b1, 3'(s), 1'b1, 2'(b));
                idle(3);
            end
        end

        cur_tag = "R3";
        for (int k = 0; k < 4; k++) begin
            logic [2:0] src = (k == 0) ? 3'd0 : 3'(4 + k);
            go(4'hF, 1'b0, 1'b1, src, 1'b1, 2'd1);
            go(4'h0, 1'b0, 1'b1, src, 1'b1, 2'd1);
            go(4'hF, 1'b0, 1'b1, src, 1'b1, 2'd1);
            idle(2);
        end

        cur_tag = "R4";
        for (int k = 0; k < 8; k++) begin
            go(4'h0, 1'b1, k[0], 3'(k), 1'b1, 2'(k));
            idle(2);
        end

        cur_tag = "R5";
        for (int s = 1; s <= 4; s++) begin
            go(4'hF, 1'b0, 1'b0, 3'(s), 1'b1, 2'd2);
            go(4'h0, 1'b0, 1'b0, 3'(s), 1'b1, 2'd2);
        end
        idle(2);

        cur_tag = "R6";
        for (int k = 0; k < 6; k++) go(4'h4, 1'b0, 1'b1, 3'd3, 1'b1, 2'd3);
        idle(3);

        cur_tag = "R8";
        for (int t = 0; t < 4; t++) begin
            go(4'h1, 1'b0, 1'b1, 3'd1, 1'b1, 2'(t));
            idle(3);
        end

        cur_tag = "R9";
        for (int t = 0; t < 4; t++) begin
            go(4'h2, 1'b0, 1'b1, 3'd2, 1'b0, 2'(t));
            idle(2);
            go(4'h0, 1'b1, 1'b0, 3'd0, 1'b1, 2'(t));
            idle(2);
        end

        cur_tag = "R10";
        go(4'h8, 1'b0, 1'b1, 3'd4, 1'b1, 2'd1);
        go(4'h0, 1'b0, 1'b1, 3'd4, 1'b1, 2'd3);
        idle(3);

        cur_tag = "R11";
        go(4'h0, 1'b1, 1'b1, 3'd0, 1'b1, 2'd0);
        go(4'h0, 1'b1, 1'b1, 3'd0, 1'b1, 2'd1);
        go(4'h0, 1'b1, 1'b1, 3'd0, 1'b1, 2'd2);
        go(4'h0, 1'b1, 1'b1, 3'd0, 1'b1, 2'd3);
        idle(3);

        cur_tag = "R7";
        for (int k = 0; k < 4000; k++) begin
            cyc(4'($urandom_range(0, 15)),
                ($urandom_range(0, 7) == 0),
                ($urandom_range(0, 3) != 0),
                3'($urandom_range(0, 7)),
                ($urandom_range(0, 3) != 0),
                2'($urandom_range(0, 3)),
                16'($urandom));
        end
        idle(2);
        @(negedge clk);
        compare_all();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule